// File: doc/BRIEF.md
# MDIO Management Frame Master

This block turns one 32-bit command word into a complete serial management transaction on the two-wire MDC/MDIO bus used to configure Ethernet PHYs. A host places the command on `cmd` and pulses `start`. The block raises `busy` and produces the management clock from the system clock. It then walks through a long run of one bits, the upper half of the command, a turnaround, a 16-bit data phase and a trailing idle clock. When the frame ends it returns a 32-bit result together with a one-cycle `done` pulse.

The data pin is open-drain. The block never drives it high. `mdio_oe` high pulls the line low, and `mdio_oe` low releases it to the external pull-up or to the PHY. A top nibble of `4'b0110` marks a read: the master releases the line from the turnaround onward and shifts in the PHY's answer. Every other nibble is treated as a write: the master sends a 1-then-0 turnaround followed by the low half of the command.

Top module: `mdio_master`

## Requirements
- R1: Each frame opens with 32 MDC periods in which the line is released (sampled high) and `mdio_oe` is low.
- R2: `mdio_oe` changes only on the system clock cycle in which MDC falls, and read data is sampled on the cycle in which MDC rises.
- R3: Each MDC low and high half lasts exactly CLK_DIV system clocks. A frame has 66+IDLE_BITS MDC periods, so `busy` stays high for 2*CLK_DIV*(66+IDLE_BITS) clocks.
- R4: A frame is a read exactly when `cmd[31:28]` equals `4'b0110`; any other value gives a write.
- R5: In MDC periods 32 to 47 (counting from 0), `cmd[31:16]` is sent MSB first. A 1 is sent by releasing the line and a 0 by pulling it low.
- R6: In the two turnaround periods (48 and 49), a read keeps `mdio_oe` low, and a write sends 1 and then 0.
- R7: In periods 50 to 65, a write sends `cmd[15:0]` MSB first, and a read keeps the line released while it shifts in 16 PHY bits MSB first.
- R8: The result of a read is `{cmd[31:16], read_data}`. The result of a write is `{16'h0000, cmd[31:16]}`.
- R9: After the data phase, the block gives IDLE_BITS further MDC periods with the line released. When the frame ends, MDC is high and `mdio_oe` is low.
- R10: `start` and `cmd` are ignored while `busy` is high. The running frame and its result are unaffected, and no second frame follows.
- R11: `done` is high for exactly one cycle per frame, with `busy` already low and `result` valid.
- R12: A synchronous reset, even in the middle of a frame, sets MDC high, `mdio_oe` low and both `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a frame; accepted only while idle |
| cmd | input | 32 | Command word: op nibble in [31:28], header in [31:16], write data in [15:0] |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| result | output | 32 | Result word, valid from `done` |
| mdc | output | 1 | Management clock, high while idle |
| mdio_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| mdio_in | input | 1 | Sensed level of the data line |

## Verification
Writes are sent with headers and data of all zeros, all ones and alternating bits. This separates a bit-order or bit-slip error from a polarity error on the open-drain output. Reads are answered by a PHY model with all-zero and all-one data, alternating data and a walking single one. The walking one exposes an off-by-one in the sampling edge or shift direction. A sweep over all sixteen op nibbles shows that only `0110` gives read behaviour. A second `start` during a frame and a reset in the middle of a frame check that the frame cannot be disturbed and that the block recovers to its resting state.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_DIV   = 10,
  parameter int IDLE_BITS = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] cmd,
  output logic        busy,
  output logic        done,
  output logic [31:0] result,
  output logic        mdc,
  output logic        mdio_oe,
  input  logic        mdio_in
);

  localparam int PRE_BITS   = 32;
  localparam int HDR_BITS   = 16;
  localparam int TA_BITS    = 2;
  localparam int DAT_BITS   = 16;
  localparam int SHIFT_BITS = HDR_BITS + TA_BITS + DAT_BITS;
  localparam int FRAME_BITS = PRE_BITS + SHIFT_BITS + IDLE_BITS;
  localparam int BW         = $clog2(FRAME_BITS + 1);
  localparam int DW         = $clog2(CLK_DIV + 1);

  localparam logic [BW-1:0] HDR_START  = BW'(PRE_BITS);
  localparam logic [BW-1:0] TA_START   = BW'(PRE_BITS + HDR_BITS);
  localparam logic [BW-1:0] DAT_START  = BW'(PRE_BITS + HDR_BITS + TA_BITS);
  localparam logic [BW-1:0] IDLE_START = BW'(PRE_BITS + SHIFT_BITS);
  localparam logic [BW-1:0] LAST_BIT   = BW'(FRAME_BITS - 1);
  localparam logic [DW-1:0] DIV_LAST   = DW'(CLK_DIV - 1);
  localparam logic [3:0]    OP_READ    = 4'b0110;

  logic [BW-1:0]         bit_idx;
  logic [DW-1:0]         div_cnt;
  logic                  high_half;
  logic                  rd_op;
  logic [15:0]           hdr_q;
  logic [SHIFT_BITS-1:0] tx_sr;
  logic [15:0]           rx_sr;

  wire [BW-1:0] next_idx = bit_idx + 1'b1;
  wire half_end = (div_cnt == DIV_LAST);
  wire in_shift = (next_idx >= HDR_START) && (next_idx < IDLE_START);
  wire in_data  = (bit_idx >= DAT_START) && (bit_idx < IDLE_START);
  wire cmd_read = (cmd[31:28] == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      mdc       <= 1'b1;
      mdio_oe   <= 1'b0;
      bit_idx   <= '0;
      div_cnt   <= '0;
      high_half <= 1'b0;
      rd_op     <= 1'b0;
      hdr_q     <= '0;
      tx_sr     <= '0;
      rx_sr     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy      <= 1'b1;
          rd_op     <= cmd_read;
          hdr_q     <= cmd[31:16];
          tx_sr     <= cmd_read ? {cmd[31:16], {(SHIFT_BITS-HDR_BITS){1'b1}}}
                                : {cmd[31:16], 2'b10, cmd[15:0]};
          bit_idx   <= '0;
          div_cnt   <= '0;
          high_half <= 1'b0;
          mdc       <= 1'b0;
          mdio_oe   <= 1'b0;
        end
      end else if (!half_end) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!high_half) begin
          high_half <= 1'b1;
          mdc       <= 1'b1;
          if (rd_op && in_data) rx_sr <= {rx_sr[14:0], mdio_in};
        end else if (bit_idx == LAST_BIT) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= rd_op ? {hdr_q, rx_sr} : {16'h0000, hdr_q};
        end else begin
          high_half <= 1'b0;
          mdc       <= 1'b0;
          bit_idx   <= next_idx;
          if (in_shift) begin
            mdio_oe <= ~tx_sr[SHIFT_BITS-1];
            tx_sr   <= {tx_sr[SHIFT_BITS-2:0], 1'b1};
          end else begin
            mdio_oe <= 1'b0;
          end
        end
      end
    end
  end

  logic          mdc_prev;
  logic [DW:0]   since_edge;
  localparam logic [DW:0] SINCE_MAX = (DW+1)'(CLK_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_prev   <= 1'b1;
      since_edge <= SINCE_MAX;
    end else begin
      mdc_prev <= mdc;
      if (mdc != mdc_prev) since_edge <= '0;
      else if (since_edge != SINCE_MAX) since_edge <= since_edge + 1'b1;
    end
  end

  p_preamble_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_idx < HDR_START) |-> !mdio_oe);

  p_oe_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_oe) |-> $fell(mdc));

  p_half_period_r3: assert property (@(posedge clk) disable iff (rst)
    (mdc != mdc_prev) |-> (since_edge >= SINCE_MAX - 1'b1));

  p_read_release_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_op && bit_idx >= TA_START) |-> !mdio_oe);

  p_rest_state_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (mdc && !mdio_oe));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(hdr_q) && $stable(rd_op)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int DIV   = 2;
  localparam int IDLE  = 1;
  localparam int NBITS = 66 + IDLE;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cmd = '0;
  logic        busy, done, mdc, mdio_oe;
  logic [31:0] result;
  logic        line;
  logic        phy_drv = 1'b0;
  logic        phy_bit = 1'b1;
  logic [15:0] phy_val = '0;
  logic        exp_read = 1'b0;

  int checks = 0;
  int errors = 0;
  int rises = 0;
  int busy_cycles = 0;
  int done_cnt = 0;
  int cyc = 0;
  logic bits [0:127];
  logic oes  [0:127];

  always #10 clk = ~clk;

  assign line = mdio_oe ? 1'b0 : (phy_drv ? phy_bit : 1'b1);

  mdio_master #(.CLK_DIV(DIV), .IDLE_BITS(IDLE)) u_mdio_master (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .busy(busy), .done(done),
    .result(result), .mdc(mdc), .mdio_oe(mdio_oe), .mdio_in(line));

  always @(posedge mdc) begin
    if (rises < 128) begin
      bits[rises] = line;
      oes[rises]  = mdio_oe;
    end
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    if (exp_read && rises >= 49 && rises <= 65) begin
      phy_drv = 1'b1;
      phy_bit = (rises == 49) ? 1'b0 : phy_val[15 - (rises - 50)];
    end else begin
      phy_drv = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (busy) busy_cycles = busy_cycles + 1;
    if (done) done_cnt = done_cnt + 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL R3 watchdog expired actual %0d expected <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] c, input logic [15:0] pv, input bit glitch);
    logic [15:0] hdr, dat;
    logic [31:0] pre_ok, rel_ok;
    logic [31:0] exp_res;
    int wait_cnt;
    exp_read = (c[31:28] == 4'b0110);
    phy_val = pv;
    @(negedge clk);
    rises = 0; busy_cycles = 0; done_cnt = 0;
    cmd = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (60) @(negedge clk);
      cmd = ~c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cmd = 32'h6000_0000;
    end
    wait_cnt = 0;
    while (!done && wait_cnt < 5000) begin
      @(negedge clk);
      wait_cnt++;
    end
    exp_res = exp_read ? {c[31:16], pv} : {16'h0000, c[31:16]};
    chk("R8 result", result, exp_res);
    chk("R11 busy low with done", {31'b0, busy}, 32'd0);
    chk("R9 rest state mdc/oe", {30'b0, mdc, mdio_oe}, 32'd2);
    chk("R3 mdc periods", rises, NBITS);
    chk("R3 busy length", busy_cycles, 2 * DIV * NBITS);
    pre_ok = '0;
    for (int i = 0; i < 32; i++) pre_ok[i] = bits[i] & ~oes[i];
    chk("R1 preamble released", pre_ok, 32'hFFFF_FFFF);
    for (int i = 0; i < 16; i++) hdr[15 - i] = bits[32 + i];
    chk("R5 header bits", {16'h0, hdr}, {16'h0, c[31:16]});
    if (exp_read) begin
      rel_ok = '0;
      for (int i = 48; i < 66; i++) rel_ok[i - 48] = ~oes[i];
      chk("R6 R7 read keeps line released", rel_ok, 32'h0003_FFFF);
      chk("R4 R6 read turnaround first bit", {31'b0, bits[48]}, 32'd1);
      for (int i = 0; i < 16; i++) dat[15 - i] = bits[50 + i];
      chk("R7 read line data", {16'h0, dat}, {16'h0, pv});
    end else begin
      chk("R4 R6 write turnaround", {30'b0, bits[48], bits[49]}, 32'd2);
      for (int i = 0; i < 16; i++) dat[15 - i] = bits[50 + i];
      chk("R7 write data bits", {16'h0, dat}, {16'h0, c[15:0]});
    end
    chk("R9 idle bit released", {31'b0, bits[66]}, 32'd1);
    repeat (12) @(negedge clk);
    chk("R11 single done pulse", done_cnt, 1);
    chk("R10 no further frame", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset state", {28'b0, mdc, mdio_oe, busy, done}, 32'h8);
    rst = 1'b0;
    @(negedge clk);

    run_frame(32'h5002_ABCD, 16'h0000, 1'b0);
    run_frame(32'h5FFF_0000, 16'h0000, 1'b0);
    run_frame(32'h5000_FFFF, 16'h0000, 1'b0);
    run_frame(32'h5AAA_5555, 16'h0000, 1'b0);
    run_frame(32'h6082_0000, 16'h0000, 1'b0);
    run_frame(32'h6FFF_1234, 16'hFFFF, 1'b0);
    run_frame(32'h6555_0000, 16'hA5A5, 1'b0);
    run_frame(32'h6AAA_FFFF, 16'h5A5A, 1'b0);
    for (int n = 0; n < 16; n++)
      run_frame({4'(n), 12'h3C5, 16'h96E1}, 16'h8001, 1'b0);
    for (int b = 0; b < 16; b++)
      run_frame(32'h6123_0000, 16'(1 << b), 1'b0);

    run_frame(32'h5AC3_1E2D, 16'h0000, 1'b1);
    run_frame(32'h6C3A_0000, 16'h7E81, 1'b1);

    exp_read = 1'b0;
    @(negedge clk);
    cmd = 32'h5123_4567; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R12 mid-frame reset", {28'b0, mdc, mdio_oe, busy, done}, 32'h8);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 stays idle after reset", {28'b0, mdc, mdio_oe, busy, done}, 32'h8);
    run_frame(32'h6001_0000, 16'hC003, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule